// File: doc/BRIEF.md
# Load-Use Hazard Stall and Branch Flush Controller

This block sits beside the decode stage of an in-order five-stage pipeline. It watches the instruction now in execute and the one now in decode. If the execute instruction is a load, and the decode instruction reads the register that the load will write, then the loaded value will not exist in time for forwarding. In that case the block freezes the program counter and the fetch/decode register for one cycle. It also forces the control word entering execute to all zeros, which sends a bubble down the pipe. On the next cycle the held instruction proceeds, and the forwarding paths supply the loaded value. Every later instruction slips by that one cycle.

The pipeline predicts every branch not taken. When a branch resolves taken, the block raises a flush that turns the fetch/decode contents into a no-op on the next clock. A flush overrides any stall detected in the same cycle, because the instruction that would have been held is on the wrong path.

All outputs are plain control levels. There is no streaming interface. Stall detection is combinational from the inputs, gated by one internal flag that records whether the previous cycle was a stall.

Top module: `lduse_stall_unit`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_rd` is non-zero, `ex_rd` equals `id_rs` or `id_rt`, no stall was issued in the previous cycle, and `br_taken` is 0, the block stalls in the same cycle.
- R2: A destination of register 0 (`ex_rd` = 0) never causes a stall.
- R3: When `ex_mem_read` is 0, no stall occurs, whatever the register fields hold.
- R4: In a stall cycle, `pc_we` = 0, `ifid_we` = 0 and `ex_bubble` = 1.
- R5: In a cycle with no stall and no flush, `pc_we` = 1, `ifid_we` = 1, `ex_bubble` = 0 and `ifid_flush` = 0.
- R6: A stall lasts exactly one cycle. The cycle after a stall does not stall, even if the inputs are unchanged.
- R7: `ifid_flush` equals `br_taken` in every cycle.
- R8: When a flush and a hazard fall in the same cycle, the flush wins: `pc_we` = 1, `ifid_we` = 1 and `ex_bubble` = 0.
- R9: Reset (`rst_n` low) clears the record of a previous stall. A hazard in the first cycle after reset stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_mem_read | input | 1 | The instruction in execute is a load |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| br_taken | input | 1 | A branch resolved taken this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_flush | output | 1 | Turns the fetch/decode register into a no-op on the next clock |
| ex_bubble | output | 1 | Zeroes the control word entering execute |

## Verification
The bench checks the destination-zero case. A design that omitted the zero test would stall on loads that discard their result. It holds one hazard for two cycles in a row. A design without the one-cycle guard would freeze the front end for as long as the inputs stay. It drives a taken branch together with a hazard. If the priority were reversed, the design would hold a wrong-path instruction and let the flush drop it. Finally, it matches the load destination against each source field separately and at the top register index. An adder-style or single-field compare would miss one of those cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic flush;
    logic bubble;
  } hzd_ctl_t;

  localparam hzd_ctl_t HZD_RUN = '{pc_we: 1'b1, ifid_we: 1'b1, flush: 1'b0, bubble: 1'b0};

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     mem_read,
  input  logic [AW-1:0]            dst,
  input  logic [NSRC-1:0][AW-1:0]  srcs,
  output logic                     hit
);
  logic [NSRC-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_cmp
      assign eq[g] = (srcs[g] == dst);
    end
  endgenerate

  assign hit = mem_read && (dst != '0) && (|eq);
endmodule

// File: rtl/hzd_seq.sv
module hzd_seq
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit,
  input  logic     br_taken,
  output hzd_ctl_t ctl
);
  logic guard_q;
  logic stall_now;

  assign stall_now = hit && !guard_q && !br_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) guard_q <= 1'b0;
    else        guard_q <= stall_now;
  end

  always_comb begin
    ctl = HZD_RUN;
    ctl.flush = br_taken;
    if (stall_now) begin
      ctl.pc_we   = 1'b0;
      ctl.ifid_we = 1'b0;
      ctl.bubble  = 1'b1;
    end
  end

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.bubble |=> !ctl.bubble);
endmodule

// File: rtl/lduse_stall_unit.sv
module lduse_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              br_taken,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              ifid_flush,
  output logic              ex_bubble
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] srcs;
  logic                        hit;
  hzd_ctl_t                    ctl;

  assign srcs = {id_rt, id_rs};

  hzd_match #(.AW(REG_AW), .NSRC(NSRC)) u_match (
    .mem_read (ex_mem_read),
    .dst      (ex_rd),
    .srcs     (srcs),
    .hit      (hit)
  );

  hzd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .br_taken (br_taken),
    .ctl      (ctl)
  );

  assign pc_we      = ctl.pc_we;
  assign ifid_we    = ctl.ifid_we;
  assign ifid_flush = ctl.flush;
  assign ex_bubble  = ctl.bubble;

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (!pc_we && !ifid_we));
  p_zero_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !ex_bubble);
  p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> !ex_bubble);
  p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (pc_we && ifid_we && !ex_bubble));
  p_we_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == ifid_we);
endmodule

// File: tb/sim_lduse_stall_unit.sv
module sim_lduse_stall_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ex_mem_read = 1'b0;
  logic [4:0] ex_rd = '0, id_rs = '0, id_rt = '0;
  logic       br_taken = 1'b0;
  logic       pc_we, ifid_we, ifid_flush, ex_bubble;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lduse_stall_unit u0 (
    .clk(clk), .rst_n(rst_n), .ex_mem_read(ex_mem_read), .ex_rd(ex_rd),
    .id_rs(id_rs), .id_rt(id_rt), .br_taken(br_taken),
    .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush), .ex_bubble(ex_bubble)
  );

  // {mem_read, rd, rs, rt, br, exp pc_we, exp ifid_we, exp flush, exp bubble}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 5'd5,  5'd5,  5'd5, 1'b0, 4'b1100},  // R3 no load
    {1'b1, 5'd5,  5'd5,  5'd3, 1'b0, 4'b0001},  // R1 rs match, R4
    {1'b0, 5'd0,  5'd0,  5'd0, 1'b0, 4'b1100},  // R5
    {1'b1, 5'd7,  5'd2,  5'd7, 1'b0, 4'b0001},  // R1 rt match
    {1'b1, 5'd7,  5'd2,  5'd7, 1'b0, 4'b1100},  // R6 repeat suppressed
    {1'b1, 5'd0,  5'd0,  5'd0, 1'b0, 4'b1100},  // R2 dest zero
    {1'b1, 5'd9,  5'd1,  5'd2, 1'b0, 4'b1100},  // R5 no match
    {1'b0, 5'd0,  5'd0,  5'd0, 1'b1, 4'b1110},  // R7 flush
    {1'b1, 5'd4,  5'd4,  5'd4, 1'b1, 4'b1110},  // R8 flush beats hazard
    {1'b1, 5'd4,  5'd4,  5'd4, 1'b0, 4'b0001},  // R1 after flush
    {1'b1, 5'd31, 5'd31, 5'd0, 1'b0, 4'b1100},  // R6 after stall
    {1'b1, 5'd31, 5'd31, 5'd0, 1'b0, 4'b0001}   // R1 top index
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, ifid_we, ifid_flush, ex_bubble};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got {pc_we,ifid_we,flush,bubble}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic mr, input logic [4:0] rd, rs, rt, input logic br);
    @(negedge clk);
    ex_mem_read = mr; ex_rd = rd; id_rs = rs; id_rt = rt; br_taken = br;
    #1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R5 reset state", 4'b1100);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19:15], VEC[i][14:10], VEC[i][9:5], VEC[i][4]);
      check($sformatf("R1-table vector %0d", i), VEC[i][3:0]);
    end

    // R9: stall, reset while guard set, same hazard stalls again
    drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
    check("R5 idle", 4'b1100);
    drive(1'b1, 5'd12, 5'd3, 5'd12, 1'b0);
    check("R4 stall before reset", 4'b0001);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R9 stall right after reset", 4'b0001);
    drive(1'b1, 5'd12, 5'd3, 5'd12, 1'b0);
    check("R6 held hazard released", 4'b1100);

    // R7: flush tracks branch input alone
    drive(1'b0, 5'd8, 5'd8, 5'd8, 1'b1);
    check("R7 flush without load", 4'b1110);
    drive(1'b0, 5'd8, 5'd8, 5'd8, 1'b0);
    check("R7 flush drops", 4'b1100);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule